// File: doc/BRIEF.md
# Countdown Interval Timer Channel

This block is one down-counting timer channel controlled through four word-wide registers. Software writes a 31-bit interval length together with a load-control bit in a single word. The channel then counts down from the interval length minus one, decrementing once per clock. It marks the end of each interval by setting a sticky flag. If interrupts are enabled, that flag drives the interrupt output.

The interval register also acts as the channel's start and stop switch. A non-zero write to an idle channel starts it. On a running channel, a zero write stops it, either at once or after the current interval, depending on the load-control bit. The same bit decides whether a new non-zero length replaces the running count at once or waits until the running interval ends. A control register selects repeat or one-shot behaviour and enables the interrupt. A status register reports the flag and whether the channel is running.

Top module: `cdt_channel`

## Requirements
- R1: Register 0 returns the stored interval length in bits 30:0 and always returns 0 in bit 31. Bit 31 is the write-only load-control bit. After reset, every register reads 0.
- R2: A non-zero write of length N to register 0 while idle makes the channel run on the next cycle, with count N-1. The count then drops by one every cycle.
- R3: A zero write to register 0 while idle leaves the channel idle, with count 0.
- R4: A running channel that receives a zero write with bit 31 set is idle one cycle later, with count 0.
- R5: A running channel that receives a non-zero write of N with bit 31 set has count N-1 one cycle later and keeps running.
- R6: A write with bit 31 clear to a running channel leaves the count unaffected. At the next interval end in repeat mode, the count reloads from the newly stored length minus one.
- R7: A zero write with bit 31 clear to a running channel lets the current interval run to count 0. The channel is then idle, with count 0.
- R8: The cycle in which a running channel holds count 0 is an interval end. The flag (register 3 bit 0) is set on the next cycle. In repeat mode (register 2 bit 1 = 0), the count reloads from the stored length minus one.
- R9: In one-shot mode (register 2 bit 1 = 1), an interval end returns the channel to idle, with count 0.
- R10: Writing 1 to register 3 bit 0 clears the flag. An interval end in the same cycle wins, and the flag stays set. Register 3 bit 1 reads 1 while the channel is running.
- R11: The irq output is high exactly while the flag is set and the interrupt enable (register 2 bit 0) is 1.
- R12: Register addresses: 0 holds the interval, 1 the current count (read-only), 2 the control bits, and 3 the status bits. rdata shows the addressed register combinationally, and reads have no side effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| we | input | 1 | Write strobe for the addressed register |
| addr | input | 2 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed register |
| irq | output | 1 | Interrupt request: flag and enable both set |

## Verification
The hardest situation to reach is a register write that lands in the same cycle as an interval end. Examples are a deferred reload or deferred stop arriving exactly at count 0, or a flag clear colliding with a new flag set. The stimulus reaches these cases by running with an interval of 1, which makes every running cycle an interval end. It also mixes in random writes of very short lengths with random load-control bits, so that writes coincide with count 0 many times.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_IVAL  = 2'd0,
    REG_COUNT = 2'd1,
    REG_CTRL  = 2'd2,
    REG_STAT  = 2'd3
  } cdt_reg_e;

  localparam int CTRL_IEN_BIT     = 0;
  localparam int CTRL_ONESHOT_BIT = 1;
  localparam int STAT_FLAG_BIT    = 0;
  localparam int STAT_RUN_BIT     = 1;

  typedef struct packed {
    logic oneshot;
    logic ien;
  } cdt_ctrl_t;
endpackage

// File: rtl/cdt_rst_sync.sv
module cdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/cdt_regfile.sv
module cdt_regfile
  import cdt_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int VAL_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  output logic              iv_wr,
  output logic [VAL_W-1:0]  iv_val,
  output logic              iv_force,
  output logic [VAL_W-1:0]  ival_q,
  output logic [VAL_W-1:0]  ival_nxt,
  output cdt_ctrl_t         ctrl_q,
  output logic              flag_q
);
  logic      ctrl_wr;
  logic      flag_clr;
  logic      flag_en;
  logic      flag_d;
  cdt_ctrl_t ctrl_d;

  // write decode
  always_comb begin
    iv_wr    = we && (addr == REG_IVAL);
    ctrl_wr  = we && (addr == REG_CTRL);
    flag_clr = we && (addr == REG_STAT) && wdata[STAT_FLAG_BIT];
    iv_val   = wdata[VAL_W-1:0];
    iv_force = wdata[DATA_W-1];
  end

  // next-state values
  always_comb begin
    ival_nxt       = iv_wr ? iv_val : ival_q;
    ctrl_d.ien     = wdata[CTRL_IEN_BIT];
    ctrl_d.oneshot = wdata[CTRL_ONESHOT_BIT];
    flag_en        = expire | flag_clr;
    flag_d         = expire | (flag_q & ~flag_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ival_q <= '0;
    end else if (iv_wr) begin
      ival_q <= iv_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int VAL_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iv_wr,
  input  logic [VAL_W-1:0] iv_val,
  input  logic             iv_force,
  input  logic [VAL_W-1:0] ival_nxt,
  input  logic             oneshot,
  output logic [VAL_W-1:0] cnt_q,
  output logic             run_q,
  output logic             expire
);
  localparam logic [VAL_W-1:0] ONE = VAL_W'(1);

  logic [VAL_W-1:0] cnt_d;
  logic             run_d;
  logic             upd_en;
  logic             wr_zero;

  assign expire  = run_q && (cnt_q == '0);
  assign wr_zero = (iv_val == '0);
  assign upd_en  = iv_wr | run_q;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (iv_wr && !run_q) begin
      // idle: a non-zero length starts the channel
      if (!wr_zero) begin
        run_d = 1'b1;
        cnt_d = iv_val - ONE;
      end
    end else if (iv_wr && iv_force) begin
      // running, immediate action
      if (wr_zero) begin
        run_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = iv_val - ONE;
      end
    end else if (expire) begin
      // interval end: reload or stop, using the latest stored length
      if (oneshot || (ival_nxt == '0)) begin
        run_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = ival_nxt - ONE;
      end
    end else if (run_q) begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end
endmodule

// File: rtl/cdt_readmux.sv
module cdt_readmux
  import cdt_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int VAL_W = DATA_W - 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [VAL_W-1:0]  ival_q,
  input  logic [VAL_W-1:0]  cnt_q,
  input  cdt_ctrl_t         ctrl_q,
  input  logic              flag_q,
  input  logic              run_q,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    case (addr)
      REG_IVAL:  rdata = {1'b0, ival_q};
      REG_COUNT: rdata = {1'b0, cnt_q};
      REG_CTRL: begin
        rdata[CTRL_IEN_BIT]     = ctrl_q.ien;
        rdata[CTRL_ONESHOT_BIT] = ctrl_q.oneshot;
      end
      default: begin
        rdata[STAT_FLAG_BIT] = flag_q;
        rdata[STAT_RUN_BIT]  = run_q;
      end
    endcase
  end
endmodule

// File: rtl/cdt_channel.sv
module cdt_channel
  import cdt_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int SYNC_STAGES = 2,
  localparam int VAL_W     = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic             rst_int_n;
  logic             iv_wr;
  logic [VAL_W-1:0] iv_val;
  logic             iv_force;
  logic [VAL_W-1:0] ival_q;
  logic [VAL_W-1:0] ival_nxt;
  cdt_ctrl_t        ctrl_q;
  logic             flag_q;
  logic [VAL_W-1:0] cnt_q;
  logic             run_q;
  logic             expire;

  cdt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  cdt_regfile #(.DATA_W(DATA_W)) u_regfile (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .we       (we),
    .addr     (addr),
    .wdata    (wdata),
    .expire   (expire),
    .iv_wr    (iv_wr),
    .iv_val   (iv_val),
    .iv_force (iv_force),
    .ival_q   (ival_q),
    .ival_nxt (ival_nxt),
    .ctrl_q   (ctrl_q),
    .flag_q   (flag_q)
  );

  cdt_counter #(.VAL_W(VAL_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .iv_wr    (iv_wr),
    .iv_val   (iv_val),
    .iv_force (iv_force),
    .ival_nxt (ival_nxt),
    .oneshot  (ctrl_q.oneshot),
    .cnt_q    (cnt_q),
    .run_q    (run_q),
    .expire   (expire)
  );

  cdt_readmux #(.DATA_W(DATA_W)) u_readmux (
    .addr   (addr),
    .ival_q (ival_q),
    .cnt_q  (cnt_q),
    .ctrl_q (ctrl_q),
    .flag_q (flag_q),
    .run_q  (run_q),
    .rdata  (rdata)
  );

  assign irq = flag_q & ctrl_q.ien;
endmodule

// File: rtl/cdt_channel_chk.sv
module cdt_channel_chk
  import cdt_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int VAL_W = DATA_W - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              irq,
  input logic [VAL_W-1:0]  cnt,
  input logic              run,
  input logic              flag,
  input logic              ien
);
  logic             wr_iv;
  logic [VAL_W-1:0] wv;
  logic             wf;

  assign wr_iv = we && (addr == REG_IVAL);
  assign wv    = wdata[VAL_W-1:0];
  assign wf    = wdata[DATA_W-1];

  assert_load_bit_reads_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == REG_IVAL) |-> !rdata[DATA_W-1]);

  assert_idle_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && wr_iv && wv != '0) |=> (run && cnt == $past(wv) - VAL_W'(1)));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt != '0 && !wr_iv) |=> (cnt == $past(cnt) - VAL_W'(1)));

  assert_idle_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && wr_iv && wv == '0) |=> !run);

  assert_force_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wr_iv && wf && wv == '0) |=> (!run && cnt == '0));

  assert_force_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wr_iv && wf && wv != '0) |=> (run && cnt == $past(wv) - VAL_W'(1)));

  assert_end_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == '0) |=> flag);

  assert_idle_count_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (cnt == '0));

  assert_irq_needs_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);

  assert_irq_when_enabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && ien) |-> irq);

  assert_count_readback_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == REG_COUNT) |-> (rdata == {1'b0, cnt}));
endmodule

bind cdt_channel cdt_channel_chk #(.DATA_W(DATA_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_int_n),
  .we    (we),
  .addr  (addr),
  .wdata (wdata),
  .rdata (rdata),
  .irq   (irq),
  .cnt   (cnt_q),
  .run   (run_q),
  .flag  (flag_q),
  .ien   (ctrl_q.ien)
);

// File: tb/cdt_channel_bench.sv
`timescale 1ns/1ps
module cdt_channel_bench;
  logic        clk;
  logic        rst_n;
  logic        we;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int n_vec;
  int n_fail;
  bit done;

  // reference state, derived from the requirements
  logic [30:0] m_ival;
  logic [30:0] m_cnt;
  logic        m_run;
  logic        m_flag;
  logic        m_ien;
  logic        m_mode;

  cdt_channel u_cdt_channel (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (we),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .irq   (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] model_read(input logic [1:0] a);
    case (a)
      2'd0:    return {1'b0, m_ival};
      2'd1:    return {1'b0, m_cnt};
      2'd2:    return {30'd0, m_mode, m_ien};
      default: return {30'd0, m_run, m_flag};
    endcase
  endfunction

  task automatic model_update(input logic w, input logic [1:0] a, input logic [31:0] d);
    logic [30:0] v;
    logic        ld;
    logic        ivw;
    logic        endv;
    logic [30:0] nival;
    logic [30:0] ncnt;
    logic        nrun;
    logic        nflag;
    v     = d[30:0];
    ld    = d[31];
    ivw   = w && (a == 2'd0);
    endv  = m_run && (m_cnt == 31'd0);
    nival = ivw ? v : m_ival;
    ncnt  = m_cnt;
    nrun  = m_run;
    if (ivw && !m_run) begin
      if (v != 0) begin nrun = 1'b1; ncnt = v - 31'd1; end
    end else if (ivw && ld) begin
      if (v == 0) begin nrun = 1'b0; ncnt = 31'd0; end
      else ncnt = v - 31'd1;
    end else if (endv) begin
      if (m_mode || nival == 0) begin nrun = 1'b0; ncnt = 31'd0; end
      else ncnt = nival - 31'd1;
    end else if (m_run) begin
      ncnt = m_cnt - 31'd1;
    end
    if (endv) nflag = 1'b1;
    else if (w && a == 2'd3 && d[0]) nflag = 1'b0;
    else nflag = m_flag;
    if (w && a == 2'd2) begin m_ien = d[0]; m_mode = d[1]; end
    m_ival = nival;
    m_cnt  = ncnt;
    m_run  = nrun;
    m_flag = nflag;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic w, input logic [1:0] a, input logic [31:0] d, input string req);
    @(negedge clk);
    we = w; addr = a; wdata = d;
    @(posedge clk);
    model_update(w, a, d);
    #1;
    check(req, rdata, model_read(a));
    check({req, "_R11_irq"}, {31'd0, irq}, {31'd0, m_flag & m_ien});
  endtask

  task automatic idle(input int n, input logic [1:0] a, input string req);
    for (int i = 0; i < n; i++) step(1'b0, a, 32'd0, req);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int seed_dummy;
    n_vec = 0; n_fail = 0; done = 1'b0;
    m_ival = '0; m_cnt = '0; m_run = 1'b0; m_flag = 1'b0; m_ien = 1'b0; m_mode = 1'b0;
    seed_dummy = $urandom(32'h5EED_0042);
    rst_n = 1'b0; we = 1'b0; addr = 2'd0; wdata = '0;
    repeat (3) @(posedge clk);
    // R1: reset values on all four registers
    for (int a = 0; a < 4; a++) begin
      @(negedge clk);
      addr = 2'(a);
      #1;
      check("R1_reset", rdata, 32'd0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    idle(3, 2'd3, "R1_reset_release");

    // R12: control register readback, interrupt enable
    step(1'b1, 2'd2, 32'h1, "R12_ctrl_write");
    // R2: start from idle with length 5, watch countdown and R8 end
    step(1'b1, 2'd0, 32'd5, "R2_start");
    idle(6, 2'd1, "R2_countdown");
    step(1'b0, 2'd3, 32'd0, "R8_flag_status");
    // R10: clear flag
    step(1'b1, 2'd3, 32'h1, "R10_w1c");
    // R5: immediate reload while running
    step(1'b1, 2'd0, 32'h8000_0003, "R5_force_load");
    step(1'b0, 2'd1, 32'd0, "R5_count");
    // R1: bit 31 reads zero after a write with it set
    step(1'b0, 2'd0, 32'd0, "R1_loadbit_read");
    // R6: deferred reload of length 2
    step(1'b1, 2'd0, 32'd2, "R6_deferred");
    idle(8, 2'd1, "R6_reload");
    // R7: deferred stop
    step(1'b1, 2'd0, 32'd0, "R7_deferred_stop");
    idle(4, 2'd1, "R7_runout");
    step(1'b0, 2'd3, 32'd0, "R7_idle_status");
    // R3: zero write while idle
    step(1'b1, 2'd0, 32'd0, "R3_idle_zero");
    step(1'b0, 2'd3, 32'd0, "R3_status");
    // R4: immediate stop
    step(1'b1, 2'd0, 32'd9, "R4_start");
    idle(2, 2'd1, "R4_run");
    step(1'b1, 2'd0, 32'h8000_0000, "R4_force_stop");
    step(1'b0, 2'd3, 32'd0, "R4_status");
    // R9: one-shot
    step(1'b1, 2'd2, 32'h3, "R9_mode");
    step(1'b1, 2'd0, 32'd2, "R9_start");
    idle(4, 2'd3, "R9_oneshot");
    step(1'b0, 2'd1, 32'd0, "R9_count");
    // R8: length 1 in repeat mode, expires every cycle
    step(1'b1, 2'd2, 32'h1, "R8_repeat");
    step(1'b1, 2'd0, 32'd1, "R8_len1");
    idle(3, 2'd3, "R8_len1_run");
    // R10: clear collides with set, set wins
    step(1'b1, 2'd3, 32'h1, "R10_collision");
    step(1'b0, 2'd3, 32'd0, "R10_after");
    // R6: deferred write landing on an end cycle
    step(1'b1, 2'd0, 32'd4, "R6_on_end");
    idle(5, 2'd1, "R6_on_end_run");
    // R11: interrupt disabled hides the flag
    step(1'b1, 2'd2, 32'h0, "R11_disable");
    step(1'b1, 2'd0, 32'h8000_0000, "R4_stop2");
    // R1: widest length
    step(1'b1, 2'd0, 32'hFFFF_FFFF, "R1_max");
    step(1'b0, 2'd0, 32'd0, "R1_max_read");
    step(1'b0, 2'd1, 32'd0, "R2_max_count");
    step(1'b1, 2'd0, 32'h8000_0000, "R4_stop_max");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic        w;
      logic [1:0]  a;
      logic [31:0] d;
      w = ($urandom % 5) < 2;
      a = 2'($urandom % 4);
      d = $urandom;
      if (w && a == 2'd0) begin
        case ($urandom % 8)
          0:       d[30:0] = 31'd0;
          7:       d[30:0] = 31'($urandom);
          default: d[30:0] = 31'(1 + $urandom % 10);
        endcase
        d[31] = ($urandom % 3) == 0;
      end
      if (w && a == 2'd1) w = 1'b0;
      step(w, a, d, "R12_random");
    end
    done = 1'b1;
    finish_run();
  end
endmodule